// File: doc/BRIEF.md
# Indexed Run-State Register Access Port

This block gives a host a narrow window onto a small bank of 8-bit registers while the device runs normally. Two adjacent I/O addresses form the window: the lower one takes a register number, and the upper one then reads or writes the register that number selects. The bank holds three general-purpose data registers, a watchdog control register and four soft-power registers (two enable, two status). Only storage and decode live here; the logic that consumes these registers sits elsewhere.

A second path, the configuration path, addresses the same eight storage cells directly. It also carries a control register whose top bit opens run-mode access, and a base-select register that moves the window among four fixed even addresses. A move programmed through the configuration path is held as pending. It is applied only when configuration mode ends, so that a host never loses the window in the middle of a session.

Read data on both paths is combinational from the registered state. Writes land on the rising clock edge. Reset is synchronous and active high.

Top module: `idxport_regbank`

## Requirements
- R1: After reset, the window's lower (index) address is 0xEA and its upper (data) address is 0xEB. The stored index, the control register, all eight bank registers and configuration address 0x30 reset as follows: index, control and bank read 0x00, and 0x30 reads 0x03.
- R2: A host cycle is claimed only when control register bit 7 (configuration address 0x03) is 1 and `cfg_mode` is 0. An unclaimed cycle drives `io_claim` low and `io_rdata` to 0x00, and it changes neither the index nor any bank register.
- R3: A claimed read of the index address returns the full value last written there. That value is held until another index write or a reset.
- R4: A claimed data-address access reaches the register selected by the stored index, using this map: 0x01 GPIO data A, 0x03 watchdog control, 0x05 GPIO data B, 0x06 GPIO data C, 0x08 and 0x09 soft-power enable 1 and 2, 0x0A and 0x0B soft-power status 1 and 2.
- R5: With any other index, a data-address read returns 0x00 and a data-address write changes no register.
- R6: Bits [1:0] of configuration address 0x30 choose the index address: 0 gives 0xE0, 1 gives 0xE2, 2 gives 0xE4, 3 gives 0xEA. The upper bits read back as 0. The data address is always the index address plus 1.
- R7: A base-select value takes effect only at the first clock edge on which `cfg_mode` is seen low after being high. Until then the previous window stays in force, and the last value written before the exit wins.
- R8: Configuration address 0x40 plus an index from the R4 map reads and writes the same cell as the run-mode path.
- R9: If both paths write the same cell in one cycle, the configuration value is kept. Writes by the two paths to different cells both take effect.
- R10: Host addresses other than the current index and data addresses are never claimed.
- R11: `io_rdata` is 0x00 in every cycle that is not a claimed read.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| cfg_mode | input | 1 | Device is in configuration mode |
| io_addr | input | AW | Host I/O address |
| io_rd | input | 1 | Host read strobe |
| io_wr | input | 1 | Host write strobe |
| io_wdata | input | DW | Host write data |
| io_rdata | output | DW | Host read data, 0 when not claimed |
| io_claim | output | 1 | This block answers the current host cycle |
| cfg_addr | input | 8 | Configuration-path register address |
| cfg_wr | input | 1 | Configuration-path write strobe |
| cfg_wdata | input | DW | Configuration-path write data |
| cfg_rdata | output | DW | Configuration-path read data |

## Verification
The bench builds the block with its defaults: 8-bit data, 8-bit host addresses and the reset base select of 3. With these values, every window position, every mapped and several unmapped index values, and the full index byte fit in a short directed run. The bench moves the window twice, once with a rewrite before exit and once by writing the base select outside configuration mode. It also drives both write paths at one cell and at two different cells in the same cycle. Finally, it resets in the middle of the run to confirm that the default window returns.

// File: rtl/idxport_regbank.sv
module idxport_regbank #(
  parameter int DW = 8,
  parameter int AW = 8,
  parameter logic [1:0] RST_SEL = 2'd3
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          cfg_mode,
  input  logic [AW-1:0] io_addr,
  input  logic          io_rd,
  input  logic          io_wr,
  input  logic [DW-1:0] io_wdata,
  output logic [DW-1:0] io_rdata,
  output logic          io_claim,
  input  logic [7:0]    cfg_addr,
  input  logic          cfg_wr,
  input  logic [DW-1:0] cfg_wdata,
  output logic [DW-1:0] cfg_rdata
);
  localparam int NREG = 8;
  localparam int SW = $clog2(NREG);
  localparam int EN_BIT = 7;
  localparam logic [7:0] CTRL_CA = 8'h03;
  localparam logic [7:0] BASE_CA = 8'h30;
  localparam logic [3:0] BANK_PAGE = 4'h4;

  function automatic logic [AW-1:0] base_of(input logic [1:0] sel);
    case (sel)
      2'd0:    base_of = AW'(8'hE0);
      2'd1:    base_of = AW'(8'hE2);
      2'd2:    base_of = AW'(8'hE4);
      default: base_of = AW'(8'hEA);
    endcase
  endfunction

  function automatic logic [SW:0] slot_of(input logic [DW-1:0] idx);
    case (idx)
      DW'(8'h01): slot_of = {1'b1, SW'(0)};
      DW'(8'h03): slot_of = {1'b1, SW'(1)};
      DW'(8'h05): slot_of = {1'b1, SW'(2)};
      DW'(8'h06): slot_of = {1'b1, SW'(3)};
      DW'(8'h08): slot_of = {1'b1, SW'(4)};
      DW'(8'h09): slot_of = {1'b1, SW'(5)};
      DW'(8'h0A): slot_of = {1'b1, SW'(6)};
      DW'(8'h0B): slot_of = {1'b1, SW'(7)};
      default:    slot_of = '0;
    endcase
  endfunction

  logic [DW-1:0] bank [NREG];
  logic [DW-1:0] ctrl_q, index_q;
  logic [1:0]    sel_q, pend_q;
  logic          mode_q;

  logic [AW-1:0] base_addr;
  logic          run_on, hit_idx, hit_dat;
  logic [SW:0]   run_slot, cfg_slot;

  assign base_addr = base_of(sel_q);
  assign run_on    = ctrl_q[EN_BIT] & ~cfg_mode;
  assign hit_idx   = io_addr == base_addr;
  assign hit_dat   = io_addr == base_addr + AW'(1);
  assign io_claim  = run_on & (io_rd | io_wr) & (hit_idx | hit_dat);
  assign run_slot  = slot_of(index_q);
  assign cfg_slot  = (cfg_addr[7:4] == BANK_PAGE) ? slot_of(DW'(cfg_addr[3:0])) : '0;

  always_ff @(posedge clk) begin
    if (rst) begin
      ctrl_q  <= '0;
      index_q <= '0;
      sel_q   <= RST_SEL;
      pend_q  <= RST_SEL;
      mode_q  <= 1'b0;
    end else begin
      mode_q <= cfg_mode;
      if (mode_q && !cfg_mode) sel_q <= pend_q;
      if (cfg_wr && cfg_addr == CTRL_CA) ctrl_q <= cfg_wdata;
      if (cfg_wr && cfg_addr == BASE_CA) pend_q <= cfg_wdata[1:0];
      if (io_claim && io_wr && hit_idx) index_q <= io_wdata;
    end
  end

  for (genvar g = 0; g < NREG; g++) begin : g_bank
    always_ff @(posedge clk) begin
      if (rst)
        bank[g] <= '0;
      else if (cfg_wr && cfg_slot == {1'b1, SW'(g)})
        bank[g] <= cfg_wdata;
      else if (io_claim && io_wr && hit_dat && run_slot == {1'b1, SW'(g)})
        bank[g] <= io_wdata;
    end
  end

  always_comb begin
    io_rdata = '0;
    if (io_claim && io_rd) begin
      if (hit_idx)          io_rdata = index_q;
      else if (run_slot[SW]) io_rdata = bank[run_slot[SW-1:0]];
    end
  end

  always_comb begin
    cfg_rdata = '0;
    if (cfg_addr == CTRL_CA)      cfg_rdata = ctrl_q;
    else if (cfg_addr == BASE_CA) cfg_rdata = DW'(pend_q);
    else if (cfg_slot[SW])        cfg_rdata = bank[cfg_slot[SW-1:0]];
  end
endmodule

// File: rtl/idxport_regbank_chk.sv
module idxport_regbank_chk #(
  parameter int DW = 8,
  parameter int AW = 8
) (
  input logic          clk,
  input logic          rst,
  input logic          cfg_mode,
  input logic          en,
  input logic          io_claim,
  input logic          io_rd,
  input logic          io_wr,
  input logic [AW-1:0] io_addr,
  input logic [DW-1:0] io_rdata,
  input logic [AW-1:0] base_addr,
  input logic [DW-1:0] index_q
);
  assert_gated_R2: assert property (@(posedge clk) disable iff (rst)
    (cfg_mode || !en) |-> !io_claim);

  assert_rdata_idle_R11: assert property (@(posedge clk) disable iff (rst)
    !(io_claim && io_rd) |-> io_rdata == '0);

  assert_base_legal_R6: assert property (@(posedge clk) disable iff (rst)
    (base_addr == AW'(8'hE0)) || (base_addr == AW'(8'hE2)) ||
    (base_addr == AW'(8'hE4)) || (base_addr == AW'(8'hEA)));

  assert_base_held_R7: assert property (@(posedge clk) disable iff (rst)
    cfg_mode |=> $stable(base_addr));

  assert_index_held_R3: assert property (@(posedge clk) disable iff (rst)
    !(io_claim && io_wr && io_addr == base_addr) |=> $stable(index_q));
endmodule

bind idxport_regbank idxport_regbank_chk #(.DW(DW), .AW(AW)) u_chk (
  .clk(clk), .rst(rst), .cfg_mode(cfg_mode), .en(ctrl_q[7]),
  .io_claim(io_claim), .io_rd(io_rd), .io_wr(io_wr), .io_addr(io_addr),
  .io_rdata(io_rdata), .base_addr(base_addr), .index_q(index_q)
);

// File: tb/tb_idxport_regbank.sv
module tb_idxport_regbank;
  logic clk = 1'b0;
  always #2.5 clk = ~clk;

  logic rst = 1'b1, cfg_mode = 1'b0;
  logic [7:0] io_addr = '0, io_wdata = '0, cfg_addr = '0, cfg_wdata = '0;
  logic io_rd = 1'b0, io_wr = 1'b0, cfg_wr = 1'b0;
  logic [7:0] io_rdata, cfg_rdata;
  logic io_claim;

  idxport_regbank dut (
    .clk(clk), .rst(rst), .cfg_mode(cfg_mode), .io_addr(io_addr), .io_rd(io_rd),
    .io_wr(io_wr), .io_wdata(io_wdata), .io_rdata(io_rdata), .io_claim(io_claim),
    .cfg_addr(cfg_addr), .cfg_wr(cfg_wr), .cfg_wdata(cfg_wdata), .cfg_rdata(cfg_rdata)
  );

  typedef struct {
    logic       claim;
    logic [7:0] rd;
    logic       chk_cfg;
    logic [7:0] cf;
    string      tag;
  } item_t;
  item_t q[$];
  int vectors = 0, miscompares = 0;
  bit done = 0;

  logic [7:0] mdl [16];

  task automatic step(input logic [7:0] a, input logic w, input logic r, input logic [7:0] d,
                      input logic [7:0] ca, input logic cw, input logic [7:0] cd,
                      input logic ec, input logic [7:0] er, input logic chk_c,
                      input logic [7:0] ecf, input string tag);
    item_t it;
    @(negedge clk);
    io_addr = a; io_wr = w; io_rd = r; io_wdata = d;
    cfg_addr = ca; cfg_wr = cw; cfg_wdata = cd;
    it.claim = ec; it.rd = er; it.chk_cfg = chk_c; it.cf = ecf; it.tag = tag;
    q.push_back(it);
  endtask

  task automatic io_read(input logic [7:0] a, input logic ec, input logic [7:0] er, input string tag);
    step(a, 0, 1, 8'h00, 8'h00, 0, 8'h00, ec, er, 0, 8'h00, tag);
  endtask
  task automatic io_write(input logic [7:0] a, input logic [7:0] d, input logic ec, input string tag);
    step(a, 1, 0, d, 8'h00, 0, 8'h00, ec, 8'h00, 0, 8'h00, tag);
  endtask
  task automatic cfg_write(input logic [7:0] ca, input logic [7:0] cd, input string tag);
    step(8'h00, 0, 0, 8'h00, ca, 1, cd, 0, 8'h00, 0, 8'h00, tag);
  endtask
  task automatic cfg_read(input logic [7:0] ca, input logic [7:0] e, input string tag);
    step(8'h00, 0, 0, 8'h00, ca, 0, 8'h00, 0, 8'h00, 1, e, tag);
  endtask
  task automatic set_mode(input logic m);
    @(negedge clk);
    io_rd = 0; io_wr = 0; cfg_wr = 0; cfg_mode = m;
  endtask
  task automatic do_reset();
    @(negedge clk);
    io_rd = 0; io_wr = 0; cfg_wr = 0; rst = 1;
    @(negedge clk);
    @(negedge clk);
    rst = 0;
    foreach (mdl[i]) mdl[i] = 8'h00;
  endtask

  function automatic bit mapped(input logic [7:0] i);
    return i == 8'h01 || i == 8'h03 || i == 8'h05 || i == 8'h06 ||
           (i >= 8'h08 && i <= 8'h0B);
  endfunction

  initial begin : monitor
    item_t it;
    forever begin
      @(negedge clk);
      #1;
      while (q.size() > 0) begin
        it = q.pop_front();
        vectors++;
        if (io_claim !== it.claim || io_rdata !== it.rd || (it.chk_cfg && cfg_rdata !== it.cf)) begin
          miscompares++;
          $display("FAIL %s: claim=%0b rdata=%02h cfg_rdata=%02h expected claim=%0b rdata=%02h cfg_rdata=%02h",
                   it.tag, io_claim, io_rdata, cfg_rdata, it.claim, it.rd, it.cf);
        end
      end
    end
  end

  initial begin : watchdog
    repeat (20000) @(posedge clk);
    if (!done) begin
      miscompares++;
      $display("FAIL watchdog: run did not finish, expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
      $finish;
    end
  end

  initial begin : driver
    foreach (mdl[i]) mdl[i] = 8'h00;
    do_reset();
    // R1 reset state, R2 closed while control bit 7 is 0
    io_read(8'hEA, 0, 8'h00, "R2 closed read");
    cfg_read(8'h03, 8'h00, "R1 ctrl reset");
    cfg_read(8'h30, 8'h03, "R1 base select reset");
    cfg_read(8'h41, 8'h00, "R1 bank reset");
    io_write(8'hEA, 8'h01, 0, "R2 closed write");
    cfg_write(8'h03, 8'h80, "R2 open");
    io_read(8'hEA, 1, 8'h00, "R1 index reset / R2 write ignored");
    io_read(8'hEB, 1, 8'h00, "R5 index 0 unmapped");
    // R4 R3 R8 mapped registers
    for (int i = 0; i < 12; i++) begin
      logic [7:0] ix = 8'(i);
      if (mapped(ix)) begin
        mdl[i] = 8'(i * 8'h11) ^ 8'hA5;
        io_write(8'hEA, ix, 1, "R3 index write");
        io_write(8'hEB, mdl[i], 1, "R4 data write");
        io_read(8'hEB, 1, mdl[i], "R4 data read");
        io_read(8'hEA, 1, ix, "R3 index readback");
        cfg_read(8'h40 | ix, mdl[i], "R8 config view");
      end
    end
    // R5 unmapped indexes
    begin
      logic [7:0] um [5] = '{8'h02, 8'h04, 8'h07, 8'h0C, 8'hFF};
      foreach (um[k]) begin
        io_write(8'hEA, um[k], 1, "R5 index write");
        io_write(8'hEB, 8'h5A, 1, "R5 data write");
        io_read(8'hEB, 1, 8'h00, "R5 unmapped read");
      end
    end
    io_read(8'hEA, 1, 8'hFF, "R3 full index byte");
    for (int i = 0; i < 12; i++)
      if (mapped(8'(i))) cfg_read(8'h40 | 8'(i), mdl[i], "R5 bank untouched");
    // R8 config write seen through window
    cfg_write(8'h45, 8'h3C, "R8 config write"); mdl[5] = 8'h3C;
    io_write(8'hEA, 8'h05, 1, "R8 index");
    io_read(8'hEB, 1, 8'h3C, "R8 shared storage");
    // R10 neighbours not claimed
    io_read(8'hE9, 0, 8'h00, "R10 below window");
    io_read(8'hEC, 0, 8'h00, "R10 above window");
    io_read(8'hE0, 0, 8'h00, "R10 other base");
    // R2 config mode gating, R6 R7 relocation
    set_mode(1);
    io_read(8'hEA, 0, 8'h00, "R2 cfg mode read");
    io_write(8'hEB, 8'h99, 0, "R2 cfg mode data write");
    io_write(8'hEA, 8'h09, 0, "R2 cfg mode index write");
    cfg_write(8'h30, 8'h01, "R6 select E2");
    cfg_read(8'h30, 8'h01, "R6 readback");
    cfg_write(8'h30, 8'hFC, "R7 rewrite to E0");
    cfg_read(8'h30, 8'h00, "R6 upper bits zero");
    set_mode(0);
    step(8'h00, 0, 0, 8'h00, 8'h00, 0, 8'h00, 0, 8'h00, 0, 8'h00, "R11 idle");
    io_read(8'hEA, 0, 8'h00, "R7 old base released");
    io_read(8'hE2, 0, 8'h00, "R7 overwritten select unused");
    io_read(8'hE0, 1, 8'h05, "R7 new base / R2 index kept");
    io_read(8'hE1, 1, 8'h3C, "R2 data write ignored");
    cfg_write(8'h30, 8'hFE, "R6 select E4 outside cfg");
    cfg_read(8'h30, 8'h02, "R6 readback masked");
    io_read(8'hE0, 1, 8'h05, "R7 not applied yet");
    io_read(8'hE4, 0, 8'h00, "R7 pending base closed");
    set_mode(1);
    set_mode(0);
    step(8'h00, 0, 0, 8'h00, 8'h00, 0, 8'h00, 0, 8'h00, 0, 8'h00, "R11 idle");
    io_read(8'hE4, 1, 8'h05, "R7 applied on exit");
    io_read(8'hE0, 0, 8'h00, "R7 prior base released");
    // R9 same-cycle writes
    io_write(8'hE4, 8'h08, 1, "R9 index 8");
    step(8'hE5, 1, 0, 8'h11, 8'h48, 1, 8'h22, 1, 8'h00, 0, 8'h00, "R9 conflict write");
    io_read(8'hE5, 1, 8'h22, "R9 config wins");
    step(8'hE5, 1, 0, 8'h33, 8'h49, 1, 8'h44, 1, 8'h00, 0, 8'h00, "R9 split write");
    io_read(8'hE5, 1, 8'h33, "R9 run write lands");
    cfg_read(8'h49, 8'h44, "R9 config write lands");
    // R2 close again
    cfg_write(8'h03, 8'h7F, "R2 clear bit 7");
    io_read(8'hE4, 0, 8'h00, "R2 closed again");
    io_read(8'hE5, 0, 8'h00, "R11 no data when closed");
    // R1 reset mid-run
    do_reset();
    cfg_read(8'h30, 8'h03, "R1 base select after reset");
    cfg_read(8'h48, 8'h00, "R1 bank cleared");
    cfg_write(8'h03, 8'h80, "R1 open");
    io_read(8'hE4, 0, 8'h00, "R1 old base gone");
    io_read(8'hEA, 1, 8'h00, "R1 default base, index cleared");
    io_read(8'hEB, 1, 8'h00, "R1 data window");
    set_mode(0);
    repeat (3) @(negedge clk);
    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end
endmodule